// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexing Controller

This block sits between a processor and a dynamic memory array whose address pins are shared between the row and column halves of an address. The processor raises a request together with a complete address and a read/write flag. The controller captures both, then drives the shared memory address bus in two phases. The upper (row) bits go out first with the row strobe. The lower (column) bits follow on the same pins with the column strobe. It drives an active-low chip select and the read/write line for the whole access. It reports the end of the access with a one-clock completion pulse.

Data lines run straight between processor and memory and do not pass through this block. The row width, the column width and the number of wait cycles after the column strobe are parameters. The defaults are an 8-bit row and an 8-bit column taken from a 16-bit address, with two wait cycles. An access occupies `WAIT_CYC + 3` clocks from the cycle after acceptance until the controller is back at idle.

Top module: `dram_addr_mux_ctrl`

## Requirements
- R1: During and directly after reset, `ras_n`, `cas_n` and `cs_n` are 1, `mfc` is 0, `mem_addr` is 0 and `mem_rw` is 1.
- R2: A request is accepted on a rising clock edge where the controller is idle and `req` is 1. `addr` and `rw` are captured on that edge, and later changes of `addr` or `rw` have no effect on the access.
- R3: In the first cycle after acceptance, `cs_n` and `ras_n` are 0, `cas_n` is 1, and `mem_addr` carries the row, i.e. `addr[ROW_W+COL_W-1:COL_W]` (zero-extended).
- R4: In the second cycle, `mem_addr` carries the column `addr[COL_W-1:0]`, `ras_n` stays 0 and `cas_n` is still 1, so the column is stable for one clock before the column strobe.
- R5: For the next `WAIT_CYC` cycles, `cas_n` and `ras_n` are 0, `mem_addr` holds the column and `mfc` is 0.
- R6: In the following cycle, `mfc` is 1 for exactly one clock while all strobes are still asserted. In the cycle after that, `ras_n`, `cas_n` and `cs_n` are 1, `mfc` is 0 and `mem_addr` is 0.
- R7: While an access is in progress, `mem_rw` equals the captured flag (1 = read, 0 = write). When idle it is 1.
- R8: A request raised while an access is in progress, including the completion cycle, is ignored. It neither starts an access nor alters the current one.
- R9: `cas_n` is never 0 unless `ras_n` is 0, and `ras_n` is never 0 unless `cs_n` is 0.
- R10: A request held high across the completion of an access is accepted on the first edge at idle, so the next row phase starts immediately after the idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Processor access request |
| addr | input | ROW_W+COL_W | Full processor address |
| rw | input | 1 | Access direction, 1 = read, 0 = write |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address pins to the memory |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| cs_n | output | 1 | Chip select, active low |
| mem_rw | output | 1 | Read/write line to the memory |
| mfc | output | 1 | Completion pulse to the processor |

## Verification
The bench corrupts `addr` and `rw` immediately after acceptance. A controller that forwarded the live inputs instead of captured ones would put the wrong row or column on the pins. A behavioural memory model in the bench latches the address on each strobe's falling edge. Its latched values expose swapped halves or a column strobe that fires before the column is on the bus.

A request kept high through the completion cycle must not restart the sequence until idle is reached. A design that accepted it early would skip the idle cycle or truncate the pulse on `mfc`. A reset in the middle of the column phase must release every strobe at once.

// File: rtl/dmc_pkg.sv
// Package: shared phase encoding for the DRAM address multiplexing controller.
// Assumes: one phase register drives all strobe decoding.
package dmc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ROW    = 3'd1,
        PH_COLSET = 3'd2,
        PH_CAS    = 3'd3,
        PH_DONE   = 3'd4
    } dmc_phase_t;
endpackage

// File: rtl/dmc_req_latch.sv
// Module: dmc_req_latch
// Holds the processor address and direction flag captured at acceptance.
// Assumes: load is a single-cycle pulse raised only when the sequencer is idle.
module dmc_req_latch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              rw_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rw_q
);
    // Capture address and direction on acceptance, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rw_q   <= 1'b1;
        end else if (load) begin
            addr_q <= addr_in;
            rw_q   <= rw_in;
        end
    end
endmodule

// File: rtl/dmc_seq.sv
// Module: dmc_seq
// Phase sequencer: idle -> row -> column setup -> column strobe (WAIT_CYC
// cycles) -> done -> idle. It accepts a request only in idle.
// Assumes: WAIT_CYC >= 1.
module dmc_seq
    import dmc_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    output logic       accept,
    output dmc_phase_t phase
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYC - 1);

    dmc_phase_t       phase_d;
    logic [CNT_W-1:0] wait_cnt;

    // Request is taken only while idle.
    assign accept = (phase == PH_IDLE) && req;

    // Next-phase selection.
    always_comb begin
        phase_d = phase;
        unique case (phase)
            PH_IDLE:   if (req) phase_d = PH_ROW;
            PH_ROW:    phase_d = PH_COLSET;
            PH_COLSET: phase_d = PH_CAS;
            PH_CAS:    if (wait_cnt == '0) phase_d = PH_DONE;
            PH_DONE:   phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_d;
    end

    // Wait counter: loaded when the column strobe starts, counts down during it.
    always_ff @(posedge clk) begin
        if (!rst_n)                    wait_cnt <= '0;
        else if (phase == PH_COLSET)   wait_cnt <= CNT_LOAD;
        else if (wait_cnt != '0)       wait_cnt <= wait_cnt - 1'b1;
    end
endmodule

// File: rtl/dmc_addr_mux.sv
// Module: dmc_addr_mux
// Puts the row or column half of the captured address on the shared pins.
// Assumes: the upper ROW_W bits are the row, the lower COL_W bits the column.
module dmc_addr_mux
    import dmc_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 8,
    parameter int MA_W  = 8
) (
    input  dmc_phase_t              phase,
    input  logic [ROW_W+COL_W-1:0]  addr_q,
    output logic [MA_W-1:0]         mem_addr
);
    logic [ROW_W-1:0] row_part;
    logic [COL_W-1:0] col_part;

    assign row_part = addr_q[ROW_W+COL_W-1:COL_W];
    assign col_part = addr_q[COL_W-1:0];

    // Select the half for the current phase; zero while idle.
    always_comb begin
        mem_addr = '0;
        unique case (phase)
            PH_ROW:                     mem_addr = MA_W'(row_part);
            PH_COLSET, PH_CAS, PH_DONE: mem_addr = MA_W'(col_part);
            default:                    mem_addr = '0;
        endcase
    end
endmodule

// File: rtl/dram_addr_mux_ctrl.sv
// Module: dram_addr_mux_ctrl
// Top level: captures a processor request, multiplexes row and column onto
// shared pins, sequences active-low strobes and chip select, and pulses mfc.
// Assumes: the data bus bypasses this block; no refresh is generated here.
module dram_addr_mux_ctrl
    import dmc_pkg::*;
#(
    parameter int ROW_W    = 8,
    parameter int COL_W    = 8,
    parameter int WAIT_CYC = 2,
    localparam int ADDR_W  = ROW_W + COL_W,
    localparam int MA_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    output logic [MA_W-1:0]   mem_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              cs_n,
    output logic              mem_rw,
    output logic              mfc
);
    logic              accept;
    dmc_phase_t        phase;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;

    dmc_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .accept (accept),
        .phase  (phase)
    );

    dmc_req_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .addr_in (addr),
        .rw_in   (rw),
        .addr_q  (addr_q),
        .rw_q    (rw_q)
    );

    dmc_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_mux (
        .phase    (phase),
        .addr_q   (addr_q),
        .mem_addr (mem_addr)
    );

    // Strobe, select, direction and completion decode from the phase.
    always_comb begin
        cs_n   = (phase == PH_IDLE);
        ras_n  = (phase == PH_IDLE);
        cas_n  = !((phase == PH_CAS) || (phase == PH_DONE));
        mfc    = (phase == PH_DONE);
        mem_rw = (phase == PH_IDLE) ? 1'b1 : rw_q;
    end
endmodule

// File: rtl/dmc_checker.sv
// Module: dmc_checker
// Port-level protocol properties of dram_addr_mux_ctrl, attached by bind.
// Assumes: synchronous active-low reset; all checks disabled while in reset.
module dmc_checker #(
    parameter int ROW_W = 8,
    parameter int COL_W = 8,
    parameter int MA_W  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req,
    input logic [ROW_W+COL_W-1:0] addr,
    input logic [MA_W-1:0]        mem_addr,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   cs_n,
    input logic                   mfc
);
    // R9: column strobe only inside the row strobe.
    assert_cas_inside_ras_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R9: row strobe only while the chip is selected.
    assert_ras_needs_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cs_n);

    // R4: the column address was already on the pins the cycle before the column strobe.
    assert_col_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(mem_addr));

    // R6: after the completion pulse everything returns inactive.
    assert_mfc_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mfc |=> (ras_n && cas_n && cs_n && !mfc));

    // R2: a row strobe starts only after an accepted request.
    assert_ras_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(req));

    // R3: the row phase carries the high bits of the address seen at acceptance.
    assert_row_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (mem_addr == MA_W'($past(addr[ROW_W+COL_W-1:COL_W]))));
endmodule

bind dram_addr_mux_ctrl dmc_checker #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .MA_W  (MA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .addr     (addr),
    .mem_addr (mem_addr),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .cs_n     (cs_n),
    .mfc      (mfc)
);

// File: tb/sim_dram_addr_mux_ctrl.sv
// Bench: sim_dram_addr_mux_ctrl
// Drives requests from a vector table, then directed cases; a small memory
// model latches the address pins on each strobe's falling edge.
module sim_dram_addr_mux_ctrl;
    localparam int ROW_W = 8;
    localparam int COL_W = 8;
    localparam int W     = 2;
    localparam int NV    = 6;

    // Each entry: {rw, addr}.
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 16'h0000}, {1'b0, 16'hFFFF}, {1'b1, 16'hA55A},
        {1'b0, 16'h01FE}, {1'b1, 16'h8001}, {1'b0, 16'h7F80}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] addr = '0;
    logic        rw = 1'b1;
    logic [7:0]  mem_addr;
    logic        ras_n, cas_n, cs_n, mem_rw, mfc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dram_addr_mux_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .WAIT_CYC(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .rw(rw),
        .mem_addr(mem_addr), .ras_n(ras_n), .cas_n(cas_n), .cs_n(cs_n),
        .mem_rw(mem_rw), .mfc(mfc)
    );

    // Memory model: latch row on ras_n fall, column on cas_n fall.
    logic       ras_prev = 1'b1, cas_prev = 1'b1;
    logic [7:0] mdl_row = '0, mdl_col = '0;
    always @(posedge clk) begin
        if (ras_prev && !ras_n) mdl_row <= mem_addr;
        if (cas_prev && !cas_n) mdl_col <= mem_addr;
        ras_prev <= ras_n;
        cas_prev <= cas_n;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Idle pin state check.
    task automatic chk_idle(input string tag);
        chk({tag, " ras_n"}, 32'(ras_n), 1);
        chk({tag, " cas_n"}, 32'(cas_n), 1);
        chk({tag, " cs_n"},  32'(cs_n), 1);
        chk({tag, " mfc"},   32'(mfc), 0);
        chk({tag, " addr"},  32'(mem_addr), 0);
        chk({tag, " rw"},    32'(mem_rw), 1);
    endtask

    // Full access with inputs scrambled after acceptance.
    task automatic run_access(input logic [15:0] a, input logic r);
        @(negedge clk); req = 1'b1; addr = a; rw = r;
        @(negedge clk); req = 1'b0; addr = ~a; rw = ~r;
        chk("R3 ras_n", 32'(ras_n), 0);
        chk("R3 cs_n", 32'(cs_n), 0);
        chk("R3 cas_n", 32'(cas_n), 1);
        chk("R3 row", 32'(mem_addr), 32'(a[15:8]));
        chk("R7 rw", 32'(mem_rw), 32'(r));
        @(negedge clk);
        chk("R4 col", 32'(mem_addr), 32'(a[7:0]));
        chk("R4 cas_n", 32'(cas_n), 1);
        chk("R4 ras_n", 32'(ras_n), 0);
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            chk("R5 cas_n", 32'(cas_n), 0);
            chk("R5 col", 32'(mem_addr), 32'(a[7:0]));
            chk("R5 mfc", 32'(mfc), 0);
        end
        @(negedge clk);
        chk("R6 mfc", 32'(mfc), 1);
        chk("R6 ras_n", 32'(ras_n), 0);
        chk("R7 rw at done", 32'(mem_rw), 32'(r));
        @(negedge clk);
        chk_idle("R6 release");
        chk("R2 model row", 32'(mdl_row), 32'(a[15:8]));
        chk("R2 model col", 32'(mdl_col), 32'(a[7:0]));
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual expired expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");

        for (int i = 0; i < NV; i++) run_access(VEC[i][15:0], VEC[i][16]);

        // R8: request held with a different address during the whole access.
        @(negedge clk); req = 1'b1; addr = 16'h3C5A; rw = 1'b0;
        @(negedge clk); addr = 16'hC3A5; rw = 1'b1;
        chk("R8 row kept", 32'(mem_addr), 32'h3C);
        repeat (W + 1) @(negedge clk);
        chk("R8 col kept", 32'(mem_addr), 32'h5A);
        chk("R8 rw kept", 32'(mem_rw), 0);
        @(negedge clk);
        chk("R8 mfc", 32'(mfc), 1);
        // R10: still held; idle cycle then the new row phase.
        @(negedge clk);
        chk("R10 idle cycle cs_n", 32'(cs_n), 1);
        @(negedge clk); req = 1'b0;
        chk("R10 new row", 32'(mem_addr), 32'hC3);
        chk("R10 ras_n", 32'(ras_n), 0);
        chk("R10 rw", 32'(mem_rw), 1);
        repeat (W + 3) @(negedge clk);
        chk_idle("R10 end");
        chk("R8 model col", 32'(mdl_col), 32'hA5);

        // R1: reset in the middle of the column strobe phase.
        @(negedge clk); req = 1'b1; addr = 16'h1234; rw = 1'b0;
        @(negedge clk); req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 pre-reset cas_n", 32'(cas_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R1 mid reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 post reset");
        run_access(16'h5AA5, 1'b1);

        finish_run();
    end
endmodule